// File: doc/BRIEF.md
# Multi-Bank GPIO Controller with Atomic Set/Clear

This block is a memory-mapped general-purpose I/O controller. It serves three banks of 32 pins each through one simple register port. The port has a byte address, a write strobe with write data, and a read strobe with registered read data. Software gives each pin a direction and an input polarity. It reads back a level view of the whole bank. It changes individual outputs through dedicated write-one-to-set and write-one-to-clear registers, so no read-modify-write sequence is needed and two agents cannot race on the output value.

The register map is grouped by register kind. Each kind owns a 16-byte block, and inside that block the banks sit at 4-byte steps. External pin inputs pass through a two-flop synchronizer before they reach the level view. Pin-side, the block drives an output value and an output enable for every pin.

Top module: `pinbank_gpio`

## Requirements
- R1: A register is addressed as kind×0x10 + bank×0x4, with kinds direction=0, polarity=1, level=2, set=3, clear=4. Address bits [1:0] are ignored, and bank b drives pins 32b to 32b+31.
- R2: In the direction register, a 1 bit makes the pin an output (`pin_oe` high) and a 0 bit makes it an input. The register reads back as written, and pin outputs change only on a write.
- R3: A write to the set register drives high every output bit whose write-data bit is 1. Bits written as 0 keep their value.
- R4: A write to the clear register drives low every output bit whose write-data bit is 1. When set and clear writes to the same bit come in consecutive cycles, the later one wins.
- R5: The set and clear registers read as zero. Writes to the level register are ignored.
- R6: A level read returns the driven output value for output pins. For input pins it returns the synchronized input XOR the polarity bit.
- R7: The polarity register reads back as written and resets to 0, which means no inversion.
- R8: A pin input change first sampled at edge E is seen by a level read sampled at edge E+2 and not by one sampled at edge E+1.
- R9: Read data is valid in the cycle after the read strobe is sampled. It is zero after any cycle without a read strobe.
- R10: Reset clears direction, polarity, output values and read data, so every pin starts as an input driving 0.
- R11: Bank slot 3 in any block, and every address at or above 0x50, reads as zero and ignores writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 8 | Byte address of the register |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_re | input | 1 | Read strobe |
| bus_rdata | output | 32 | Registered read data |
| pin_in | input | 96 | Raw external pin levels |
| pin_out | output | 96 | Output value per pin |
| pin_oe | output | 96 | Output enable per pin |

## Verification
The hardest case to reach is the exact synchronizer delay seen through a level read. The bench changes one bank's inputs on a falling edge and then issues two level reads back to back. The first read must still return the old value and the second must return the new one. The later-write-wins rule is reached by sending set and clear writes for the same bit in consecutive cycles, in both orders. Aliasing is checked by writing to the unused bank slot and to high addresses, then confirming that every real bank's outputs kept their values.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
    localparam int BANK_W     = 32;
    localparam int SLOT_BYTES = 4;
    localparam int BLOCK_BYTES = 16;
    localparam int NUM_SLOTS  = BLOCK_BYTES / SLOT_BYTES;
    localparam int SLOT_IDX_W = $clog2(NUM_SLOTS);
    localparam int NUM_KINDS  = 5;

    typedef enum logic [2:0] {
        KIND_DIR   = 3'd0,
        KIND_POL   = 3'd1,
        KIND_LEVEL = 3'd2,
        KIND_SET   = 3'd3,
        KIND_CLR   = 3'd4
    } reg_kind_e;
endpackage

// File: rtl/gpio_sync2.sv
module gpio_sync2 #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] raw,
    output logic [W-1:0] synced
);
    logic [W-1:0] stage1;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stage1 <= '0;
            synced <= '0;
        end else begin
            stage1 <= raw;
            synced <= stage1;
        end
    end
endmodule

// File: rtl/gpio_addr_decode.sv
module gpio_addr_decode
    import gpio_pkg::*;
#(
    parameter int ADDR_W    = 8,
    parameter int NUM_BANKS = 3
) (
    input  logic [ADDR_W-1:0]     addr,
    output logic                  hit,
    output reg_kind_e             kind,
    output logic [SLOT_IDX_W-1:0] slot
);
    localparam int BLK_W = ADDR_W - $clog2(BLOCK_BYTES);

    logic [BLK_W-1:0] blk;
    logic             unused_low;

    assign unused_low = &{1'b0, addr[1:0]};

    always_comb begin
        blk  = addr[ADDR_W-1:$clog2(BLOCK_BYTES)];
        slot = addr[$clog2(BLOCK_BYTES)-1:$clog2(SLOT_BYTES)];
        kind = KIND_DIR;
        hit  = 1'b0;
        if ((32'(blk) < NUM_KINDS) && (32'(slot) < NUM_BANKS)) begin
            hit  = 1'b1;
            kind = reg_kind_e'(blk[2:0]);
        end
    end
endmodule

// File: rtl/gpio_bank.sv
module gpio_bank #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_dir,
    input  logic         wr_pol,
    input  logic         wr_set,
    input  logic         wr_clr,
    input  logic [W-1:0] wdata,
    input  logic [W-1:0] pin_sync,
    output logic [W-1:0] dir_q,
    output logic [W-1:0] pol_q,
    output logic [W-1:0] out_q,
    output logic [W-1:0] level
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dir_q <= '0;
            pol_q <= '0;
            out_q <= '0;
        end else begin
            if (wr_dir) dir_q <= wdata;
            if (wr_pol) pol_q <= wdata;
            if (wr_set)      out_q <= out_q | wdata;
            else if (wr_clr) out_q <= out_q & ~wdata;
        end
    end

    assign level = (dir_q & out_q) | (~dir_q & (pin_sync ^ pol_q));
endmodule

// File: rtl/pinbank_gpio.sv
module pinbank_gpio
    import gpio_pkg::*;
#(
    parameter int ADDR_W    = 8,
    parameter int NUM_BANKS = 3,
    localparam int PINS     = NUM_BANKS * BANK_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [BANK_W-1:0] bus_wdata,
    input  logic              bus_re,
    output logic [BANK_W-1:0] bus_rdata,
    input  logic [PINS-1:0]   pin_in,
    output logic [PINS-1:0]   pin_out,
    output logic [PINS-1:0]   pin_oe
);
    logic                  hit;
    reg_kind_e             kind;
    logic [SLOT_IDX_W-1:0] slot;
    logic [PINS-1:0]       pin_sync;
    logic [BANK_W-1:0]     dir_arr   [NUM_SLOTS];
    logic [BANK_W-1:0]     pol_arr   [NUM_SLOTS];
    logic [BANK_W-1:0]     out_arr   [NUM_SLOTS];
    logic [BANK_W-1:0]     level_arr [NUM_SLOTS];
    logic [BANK_W-1:0]     rd_mux;

    gpio_addr_decode #(.ADDR_W(ADDR_W), .NUM_BANKS(NUM_BANKS)) u_dec (
        .addr (bus_addr),
        .hit  (hit),
        .kind (kind),
        .slot (slot)
    );

    gpio_sync2 #(.W(PINS)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .raw    (pin_in),
        .synced (pin_sync)
    );

    for (genvar b = 0; b < NUM_SLOTS; b++) begin : g_slot
        if (b < NUM_BANKS) begin : g_bank
            logic sel;
            assign sel = bus_we && hit && (32'(slot) == b);
            gpio_bank #(.W(BANK_W)) u_bank (
                .clk      (clk),
                .rst_n    (rst_n),
                .wr_dir   (sel && (kind == KIND_DIR)),
                .wr_pol   (sel && (kind == KIND_POL)),
                .wr_set   (sel && (kind == KIND_SET)),
                .wr_clr   (sel && (kind == KIND_CLR)),
                .wdata    (bus_wdata),
                .pin_sync (pin_sync[b*BANK_W +: BANK_W]),
                .dir_q    (dir_arr[b]),
                .pol_q    (pol_arr[b]),
                .out_q    (out_arr[b]),
                .level    (level_arr[b])
            );
            assign pin_out[b*BANK_W +: BANK_W] = out_arr[b];
            assign pin_oe[b*BANK_W +: BANK_W]  = dir_arr[b];
        end else begin : g_empty
            assign dir_arr[b]   = '0;
            assign pol_arr[b]   = '0;
            assign out_arr[b]   = '0;
            assign level_arr[b] = '0;
        end
    end

    always_comb begin
        rd_mux = '0;
        if (hit) begin
            unique case (kind)
                KIND_DIR:   rd_mux = dir_arr[slot];
                KIND_POL:   rd_mux = pol_arr[slot];
                KIND_LEVEL: rd_mux = level_arr[slot];
                default:    rd_mux = '0;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) bus_rdata <= '0;
        else        bus_rdata <= bus_re ? rd_mux : '0;
    end
endmodule

// File: rtl/gpio_ctrl_checker.sv
module gpio_ctrl_checker #(
    parameter int ADDR_W = 8,
    parameter int PINS   = 96
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_we,
    input logic [31:0]       bus_wdata,
    input logic              bus_re,
    input logic [31:0]       bus_rdata,
    input logic [PINS-1:0]   pin_out,
    input logic [PINS-1:0]   pin_oe
);
    logic set_b0, clr_b0, high_addr;
    assign set_b0    = bus_we && ((bus_addr >> 2) == ADDR_W'(12));
    assign clr_b0    = bus_we && ((bus_addr >> 2) == ADDR_W'(16));
    assign high_addr = bus_addr >= ADDR_W'(8'h50);

    AST_RESET_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (pin_oe == '0 && pin_out == '0)); // R10
    AST_NO_WRITE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_we |=> ($stable(pin_oe) && $stable(pin_out))); // R2
    AST_SET_BANK0: assert property (@(posedge clk) disable iff (!rst_n)
        set_b0 |=> pin_out[31:0] == ($past(pin_out[31:0]) | $past(bus_wdata))); // R3
    AST_CLR_BANK0: assert property (@(posedge clk) disable iff (!rst_n)
        clr_b0 |=> pin_out[31:0] == ($past(pin_out[31:0]) & ~$past(bus_wdata))); // R4
    AST_IDLE_RDATA_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_re |=> bus_rdata == '0); // R9
    AST_HIGH_ADDR_INERT: assert property (@(posedge clk) disable iff (!rst_n)
        high_addr |=> ($stable(pin_oe) && $stable(pin_out) && bus_rdata == '0)); // R11
endmodule

bind pinbank_gpio gpio_ctrl_checker #(.ADDR_W(ADDR_W), .PINS(PINS)) u_chk (.*);

// File: tb/sim_pinbank_gpio.sv
module sim_pinbank_gpio;
    localparam int CLK_PERIOD = 10;

    typedef struct {
        logic [31:0] val;
        string       req;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic        bus_re = 1'b0;
    logic [31:0] bus_rdata;
    logic [95:0] pin_in = '0;
    logic [95:0] pin_out, pin_oe;

    int   n_chk = 0;
    int   n_err = 0;
    exp_t scb[$];
    logic re_seen;

    always #(CLK_PERIOD/2) clk = ~clk;

    pinbank_gpio u0 (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_re(bus_re), .bus_rdata(bus_rdata),
        .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe)
    );

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(logic [7:0] a, logic [31:0] d);
        @(negedge clk);
        bus_we = 1'b1; bus_re = 1'b0; bus_addr = a; bus_wdata = d;
    endtask

    task automatic rd(logic [7:0] a, logic [31:0] e, string req);
        exp_t it;
        @(negedge clk);
        bus_we = 1'b0; bus_re = 1'b1; bus_addr = a;
        it.val = e; it.req = req;
        scb.push_back(it);
    endtask

    task automatic idle();
        @(negedge clk);
        bus_we = 1'b0; bus_re = 1'b0;
    endtask

    always @(posedge clk) re_seen <= bus_re;

    always @(negedge clk) begin
        if (re_seen === 1'b1) begin
            if (scb.size() == 0) begin
                chk("R9 unexpected read", bus_rdata, 32'hx);
            end else begin
                exp_t it;
                it = scb.pop_front();
                chk(it.req, bus_rdata, it.val);
            end
        end
    end

    initial begin
        #(CLK_PERIOD * 20000);
        n_chk++; n_err++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        pin_in[31:0] = 32'h1234_5678;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R10 reset state
        chk("R10 oe", pin_oe[31:0], 32'h0);
        chk("R10 out", pin_out[95:64], 32'h0);
        chk("R10 rdata", bus_rdata, 32'h0);
        rd(8'h00, 32'h0, "R10 dir reset");
        rd(8'h14, 32'h0, "R7 pol reset");
        // R2 direction
        wr(8'h00, 32'h0000_FFFF);
        wr(8'h08, 32'hF000_0000);
        idle();
        chk("R2 oe bank0", pin_oe[31:0], 32'h0000_FFFF);
        chk("R2 oe bank2", pin_oe[95:64], 32'hF000_0000);
        rd(8'h00, 32'h0000_FFFF, "R2 dir readback");
        // R1 low address bits ignored, bank1 mapping
        wr(8'h05, 32'hA5A5_A5A5);
        idle();
        chk("R1 oe bank1", pin_oe[63:32], 32'hA5A5_A5A5);
        rd(8'h06, 32'hA5A5_A5A5, "R1 alias readback");
        // R3 set
        wr(8'h30, 32'h0000_00F3);
        idle();
        chk("R3 set", pin_out[31:0], 32'h0000_00F3);
        wr(8'h30, 32'h0000_0100);
        idle();
        chk("R3 zero bits kept", pin_out[31:0], 32'h0000_01F3);
        // R4 clear and later-wins
        wr(8'h40, 32'h0000_0003);
        idle();
        chk("R4 clear", pin_out[31:0], 32'h0000_01F0);
        wr(8'h34, 32'h1);
        wr(8'h44, 32'h1);
        idle();
        chk("R4 set then clear", pin_out[63:32], 32'h0);
        wr(8'h44, 32'h2);
        wr(8'h34, 32'h2);
        idle();
        chk("R4 clear then set", pin_out[63:32], 32'h2);
        // R5 set/clear read zero, level writes ignored
        rd(8'h30, 32'h0, "R5 set reads zero");
        rd(8'h44, 32'h0, "R5 clear reads zero");
        wr(8'h20, 32'hFFFF_FFFF);
        idle();
        chk("R5 level write ignored", pin_out[31:0], 32'h0000_01F0);
        // R6 level view, R7 polarity
        rd(8'h20, 32'h1234_01F0, "R6 level mixed");
        wr(8'h10, 32'hFFFF_000F);
        rd(8'h10, 32'hFFFF_000F, "R7 pol readback");
        rd(8'h20, 32'hEDCB_01F0, "R6 inverted inputs");
        // R8 synchronizer delay
        idle();
        @(negedge clk);
        pin_in[95:64] = 32'hFABC_DEF5;
        rd(8'h28, 32'h0, "R8 edge E+1 old");
        rd(8'h28, 32'h0ABC_DEF5, "R8 edge E+2 new");
        idle();
        // R9 idle read data zero
        @(negedge clk);
        chk("R9 idle zero", bus_rdata, 32'h0);
        // R11 unmapped
        wr(8'h3C, 32'hFFFF_FFFF);
        wr(8'h50, 32'hFFFF_FFFF);
        wr(8'h80, 32'hFFFF_FFFF);
        wr(8'h0C, 32'h0);
        idle();
        chk("R11 out bank0", pin_out[31:0], 32'h0000_01F0);
        chk("R11 out bank1", pin_out[63:32], 32'h2);
        chk("R11 out bank2", pin_out[95:64], 32'h0);
        chk("R11 oe bank0", pin_oe[31:0], 32'h0000_FFFF);
        rd(8'h0C, 32'h0, "R11 slot3 read");
        rd(8'h50, 32'h0, "R11 high read");
        idle();
        repeat (3) @(negedge clk);
        chk("R9 all reads answered", 32'(scb.size()), 32'h0);
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule